// File: doc/BRIEF.md
# Sync-Framed Serial Deserializer Receiver

This block sits at the receiving end of a framed serial read link. It takes a serial clock, a frame sync line and a serial data line, and rebuilds parallel results from them. Both lines are sampled on falling clock edges. The receiver finds frame boundaries from rising edges of the sync line. It then produces either complete 16-bit words (word framing) or an upper byte followed by a lower byte (byte framing). Each result comes with a valid strobe one clock wide.

A frame starts at the first falling edge where sync is seen high after it was low. Data is launched MSB first, starting at the second rising edge of the frame. The frame's data only becomes complete after the sync rise that opens the next frame. So a result is produced at the second rising edge after that next sync rise. In word framing this is rising edge 18 of the frame. In byte framing the upper byte comes out at rising edge 10 and the lower byte at rising edge 18 of the word.

The control is a state machine clocked on falling edges, with three states:
- **SEEK**: hunting for the first sync rise.
- **COUNT**: counting the falling edges of a frame.
- **CLOSE**: the single falling edge on which a completed frame is handed to the output stage.

Its transitions are:
- SEEK→COUNT on a sync rise.
- COUNT→CLOSE on a sync rise that arrives on time.
- COUNT→COUNT (restart with error) on an early sync rise.
- COUNT→SEEK (with error) when an expected sync rise is missing.
- CLOSE→COUNT always.

Top module: `sfd_rx`

## Requirements
- R1: `sync_in` and `sdata` are sampled only on falling edges of `sclk`. A frame begins at the falling edge where `sync_in` is sampled 1 after being sampled 0.
- R2: In word mode (`byte_mode`=0 at frame start), the word is the 16 bits sampled on falling edges 3 to 18 of the frame, MSB first. It appears on `word_q` with `word_vld` at rising edge 18, provided the next sync rise comes exactly 16 clocks after the previous one.
- R3: In byte mode (`byte_mode`=1 at frame start), frames last 8 clocks. The first byte frame after a (re)start is an upper byte. Its 8 bits, sampled on falling edges 3 to 10 and MSB first, appear on `hi_q` with `hi_vld` at rising edge 10.
- R4: Byte frames alternate upper and lower. A lower byte appears on `lo_q` with `lo_vld` at rising edge 18 of the word. A lower byte is only ever reported after an upper byte.
- R5: `word_vld`, `hi_vld`, `lo_vld` and `frame_err` are each high for exactly one clock, and at most one of them is high in any cycle.
- R6: `word_q`, `hi_q` and `lo_q` hold their values in every cycle in which their own strobe is low.
- R7: If a sync rise is missing where one is expected, `frame_err` pulses at the rising edge that follows the expected falling edge. The unfinished frame yields no data, and the receiver returns to SEEK.
- R8: A sync rise that arrives before the frame length has elapsed causes a `frame_err` pulse at the next rising edge. That rise starts a new frame, and the byte phase returns to upper.
- R9: The first frame after reset or after a resynchronisation yields no result until a following sync rise closes it.
- R10: An active-low asynchronous `rst_n` clears all outputs, the shift register and the counters, and puts the receiver in SEEK.
- R11: `byte_mode` is sampled only when a frame starts. Changing it inside a frame has no effect on that frame's length or result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; data and sync sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Frame sync; each rising edge marks a frame start |
| sdata | input | 1 | Serial data, MSB first |
| byte_mode | input | 1 | 0 = 16-bit word framing, 1 = 8-bit byte framing |
| word_q | output | 16 | Last received word |
| word_vld | output | 1 | One-clock strobe for `word_q` |
| hi_q | output | 8 | Last received upper byte |
| hi_vld | output | 1 | One-clock strobe for `hi_q` |
| lo_q | output | 8 | Last received lower byte |
| lo_vld | output | 1 | One-clock strobe for `lo_q` |
| frame_err | output | 1 | One-clock strobe on a missing or early sync rise |

## Verification
The bound checker watches several properties on every rising edge:
- every strobe is one clock wide, and no two strobes are high together;
- outputs hold between their strobes;
- successive word strobes, and successive byte strobes, are never closer than one frame length;
- a lower byte never appears without an upper byte before it.

Other properties depend on what was sent, so only the bench scenarios can show them:
- the bit order and data values;
- the exact rising edge on which each result appears;
- that a missing or early sync raises the error at the right edge;
- that the first frame after a restart is withheld;
- that a mid-frame change of `byte_mode` is ignored.

// File: rtl/sfd_pkg.sv
`timescale 1ns/1ps
package sfd_pkg;

    // framer states, advanced on falling edges of the serial clock
    typedef enum logic [1:0] {
        ST_SEEK  = 2'd0,
        ST_COUNT = 2'd1,
        ST_CLOSE = 2'd2
    } rx_state_t;

    // kind of result handed from the framer to the output stage
    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_WORD = 2'd1,
        CAP_HI   = 2'd2,
        CAP_LO   = 2'd3
    } cap_kind_t;

endpackage

// File: rtl/sfd_sampler.sv
`timescale 1ns/1ps
module sfd_sampler #(
    parameter int WORD_W = 16
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic              sdata,
    output logic              sync_rise,
    output logic [WORD_W-1:0] shreg
);

    logic sync_d;

    // R1: both lines captured on the falling edge; shift runs freely
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            sync_d <= 1'b0;
            shreg  <= '0;
        end else begin
            sync_d <= sync_in;
            shreg  <= {shreg[WORD_W-2:0], sdata};
        end
    end

    // rise seen at this falling edge: high now, low at the previous one
    assign sync_rise = sync_in & ~sync_d;

endmodule

// File: rtl/sfd_framer.sv
`timescale 1ns/1ps
module sfd_framer
    import sfd_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic      sclk,
    input  logic      rst_n,
    input  logic      sync_rise,
    input  logic      byte_mode,
    output cap_kind_t cap_kind,
    output logic      err_req
);

    localparam int BYTE_W = WORD_W / 2;
    localparam int CW     = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] WORD_LEN = CW'(WORD_W);
    localparam logic [CW-1:0] BYTE_LEN = CW'(BYTE_W);

    rx_state_t      state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;
    logic           cur_byte, cur_byte_nx;
    logic           lo_next, lo_next_nx;
    cap_kind_t      kind_nx;
    logic           err_nx;
    logic [CW-1:0]  len;
    logic           at_len;

    assign len    = cur_byte ? BYTE_LEN : WORD_LEN;
    assign at_len = (cnt == len);

    always_comb begin
        state_nx    = state;
        cnt_nx      = cnt;
        cur_byte_nx = cur_byte;
        lo_next_nx  = lo_next;
        kind_nx     = CAP_NONE;
        err_nx      = 1'b0;
        unique case (state)
            ST_SEEK: begin
                if (sync_rise) begin
                    state_nx    = ST_COUNT;
                    cnt_nx      = CW'(1);
                    cur_byte_nx = byte_mode;        // R11
                    lo_next_nx  = 1'b0;
                end
            end
            ST_COUNT: begin
                if (sync_rise) begin
                    if (at_len) begin
                        state_nx = ST_CLOSE;
                        cnt_nx   = CW'(1);
                    end else begin
                        // R8: early rise restarts the frame
                        err_nx      = 1'b1;
                        cnt_nx      = CW'(1);
                        cur_byte_nx = byte_mode;
                        lo_next_nx  = 1'b0;
                    end
                end else if (at_len) begin
                    // R7: expected rise missing
                    err_nx   = 1'b1;
                    state_nx = ST_SEEK;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_CLOSE: begin
                // last bit of the previous frame arrives on this edge
                state_nx = ST_COUNT;
                cnt_nx   = CW'(2);
                if (cur_byte) begin
                    kind_nx    = lo_next ? CAP_LO : CAP_HI;
                    lo_next_nx = ~lo_next;
                end else begin
                    kind_nx    = CAP_WORD;
                    lo_next_nx = 1'b0;
                end
                cur_byte_nx = byte_mode;
                if (byte_mode != cur_byte) begin
                    lo_next_nx = 1'b0;
                end
            end
            default: begin
                state_nx = ST_SEEK;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_SEEK;
            cnt      <= '0;
            cur_byte <= 1'b0;
            lo_next  <= 1'b0;
        end else begin
            state    <= state_nx;
            cnt      <= cnt_nx;
            cur_byte <= cur_byte_nx;
            lo_next  <= lo_next_nx;
        end
    end

    // outputs
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            cap_kind <= CAP_NONE;
            err_req  <= 1'b0;
        end else begin
            cap_kind <= kind_nx;
            err_req  <= err_nx;
        end
    end

endmodule

// File: rtl/sfd_outlatch.sv
`timescale 1ns/1ps
module sfd_outlatch
    import sfd_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  cap_kind_t           cap_kind,
    input  logic                err_req,
    input  logic [WORD_W-1:0]   shreg,
    output logic [WORD_W-1:0]   word_q,
    output logic                word_vld,
    output logic [WORD_W/2-1:0] hi_q,
    output logic                hi_vld,
    output logic [WORD_W/2-1:0] lo_q,
    output logic                lo_vld,
    output logic                frame_err
);

    localparam int BYTE_W = WORD_W / 2;

    // requests last from one falling edge to the next, so exactly one
    // rising edge sees each of them
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
            word_vld  <= 1'b0;
            hi_vld    <= 1'b0;
            lo_vld    <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            word_vld  <= (cap_kind == CAP_WORD);
            hi_vld    <= (cap_kind == CAP_HI);
            lo_vld    <= (cap_kind == CAP_LO);
            frame_err <= err_req;
            if (cap_kind == CAP_WORD) word_q <= shreg;
            if (cap_kind == CAP_HI)   hi_q   <= shreg[BYTE_W-1:0];
            if (cap_kind == CAP_LO)   lo_q   <= shreg[BYTE_W-1:0];
        end
    end

endmodule

// File: rtl/sfd_rx.sv
`timescale 1ns/1ps
module sfd_rx
    import sfd_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                sync_in,
    input  logic                sdata,
    input  logic                byte_mode,
    output logic [WORD_W-1:0]   word_q,
    output logic                word_vld,
    output logic [WORD_W/2-1:0] hi_q,
    output logic                hi_vld,
    output logic [WORD_W/2-1:0] lo_q,
    output logic                lo_vld,
    output logic                frame_err
);

    logic              sync_rise;
    logic [WORD_W-1:0] shreg;
    cap_kind_t         cap_kind;
    logic              err_req;

    sfd_sampler #(.WORD_W(WORD_W)) u_smp (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .sdata     (sdata),
        .sync_rise (sync_rise),
        .shreg     (shreg)
    );

    sfd_framer #(.WORD_W(WORD_W)) u_frm (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .sync_rise (sync_rise),
        .byte_mode (byte_mode),
        .cap_kind  (cap_kind),
        .err_req   (err_req)
    );

    sfd_outlatch #(.WORD_W(WORD_W)) u_out (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .cap_kind  (cap_kind),
        .err_req   (err_req),
        .shreg     (shreg),
        .word_q    (word_q),
        .word_vld  (word_vld),
        .hi_q      (hi_q),
        .hi_vld    (hi_vld),
        .lo_q      (lo_q),
        .lo_vld    (lo_vld),
        .frame_err (frame_err)
    );

endmodule

// File: rtl/sfd_rx_chk.sv
`timescale 1ns/1ps
module sfd_rx_chk #(
    parameter int WORD_W = 16
) (
    input logic                sclk,
    input logic                rst_n,
    input logic [WORD_W-1:0]   word_q,
    input logic                word_vld,
    input logic [WORD_W/2-1:0] hi_q,
    input logic                hi_vld,
    input logic [WORD_W/2-1:0] lo_q,
    input logic                lo_vld,
    input logic                frame_err
);

    localparam int BYTE_W = WORD_W / 2;
    localparam int GW     = $clog2(WORD_W + 1);
    localparam logic [GW-1:0] WMAX = GW'(WORD_W);
    localparam logic [GW-1:0] BMAX = GW'(BYTE_W);

    logic [GW-1:0] wgap, bgap;
    logic          hi_seen;

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            wgap    <= WMAX;
            bgap    <= BMAX;
            hi_seen <= 1'b0;
        end else begin
            if (word_vld)          wgap <= GW'(1);
            else if (wgap < WMAX)  wgap <= wgap + 1'b1;
            if (hi_vld || lo_vld)  bgap <= GW'(1);
            else if (bgap < BMAX)  bgap <= bgap + 1'b1;
            if (hi_vld)                              hi_seen <= 1'b1;
            else if (lo_vld || word_vld || frame_err) hi_seen <= 1'b0;
        end
    end

    // R5
    strobe_excl_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        $onehot0({word_vld, hi_vld, lo_vld, frame_err}));
    // R5
    word_pulse_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    // R5
    hi_pulse_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        hi_vld |=> !hi_vld);
    // R5
    lo_pulse_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        lo_vld |=> !lo_vld);
    // R7
    err_pulse_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        frame_err |=> !frame_err);
    // R6
    word_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        !word_vld |-> $stable(word_q));
    // R6
    hi_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        !hi_vld |-> $stable(hi_q));
    // R6
    lo_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        !lo_vld |-> $stable(lo_q));
    // R2
    word_gap_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        word_vld |-> (wgap >= WMAX));
    // R3
    byte_gap_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (hi_vld || lo_vld) |-> (bgap >= BMAX));
    // R4
    lo_order_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        lo_vld |-> hi_seen);

endmodule

bind sfd_rx sfd_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .word_q    (word_q),
    .word_vld  (word_vld),
    .hi_q      (hi_q),
    .hi_vld    (hi_vld),
    .lo_q      (lo_q),
    .lo_vld    (lo_vld),
    .frame_err (frame_err)
);

// File: tb/sim_sfd_rx.sv
`timescale 1ns/1ps
module sim_sfd_rx;

    localparam int W = 16;
    localparam int B = 8;
    localparam int NV = 5;
    // {byte_mode, first value, second value}
    localparam logic [32:0] VEC [0:NV-1] = '{
        {1'b0, 16'hA5C3, 16'h0001},
        {1'b1, 16'h3C96, 16'h7E01},
        {1'b0, 16'hFFFF, 16'h8000},
        {1'b1, 16'h00FF, 16'hFF00},
        {1'b0, 16'h1234, 16'hFEDC}
    };

    logic sclk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic sdata = 1'b0;
    logic byte_mode = 1'b0;
    logic [W-1:0] word_q;
    logic [B-1:0] hi_q, lo_q;
    logic word_vld, hi_vld, lo_vld, frame_err;

    logic [W-1:0] frm [0:7];
    int errs = 0;
    int checks = 0;
    bit done = 0;

    sfd_rx #(.WORD_W(W)) u0 (
        .sclk(sclk), .rst_n(rst_n), .sync_in(sync_in), .sdata(sdata),
        .byte_mode(byte_mode), .word_q(word_q), .word_vld(word_vld),
        .hi_q(hi_q), .hi_vld(hi_vld), .lo_q(lo_q), .lo_vld(lo_vld),
        .frame_err(frame_err)
    );

    always #2 sclk = ~sclk;   // 250 MHz

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // launch on a rising edge, then wait past the falling sample edge
    task automatic edge_drive(logic s, logic d);
        @(posedge sclk);
        #1;
        sync_in = s;
        sdata   = d;
        @(negedge sclk);
        #0.2;
    endtask

    task automatic run_frames(bit bm, int n, bit fresh, bit err_e1, bit glitch);
        int p;
        int last;
        p = bm ? B : W;
        last = n * p + p + 1;
        byte_mode = bm;
        for (int e = 0; e <= last; e++) begin
            int j;
            int k;
            logic d;
            logic s;
            j = e - 2;
            d = 1'b0;
            s = ((e % p) == 0) && (e <= n * p);
            if (j >= 0 && j < n * p) d = frm[j / p][p - 1 - (j % p)];
            if (glitch) byte_mode = (e >= 5 && e <= 10) ? ~bm : bm;
            edge_drive(s, d);
            if (e >= p + 2 && ((e - 2) % p) == 0) begin
                k = (e - 2) / p - 1;
                if (!bm) begin
                    chk("R2", "word_vld", word_vld, 1);
                    chk("R2", "word_q", word_q, frm[k]);
                end else if ((k % 2) == 0) begin
                    chk("R3", "hi_vld", hi_vld, 1);
                    chk("R3", "hi_q", hi_q, frm[k][B-1:0]);
                end else begin
                    chk("R4", "lo_vld", lo_vld, 1);
                    chk("R4", "lo_q", lo_q, frm[k][B-1:0]);
                end
                if (glitch) chk("R11", "word_q glitch", word_q, frm[k]);
            end else if (e >= p + 3 && ((e - 3) % p) == 0) begin
                chk("R5", "strobes after pulse", {word_vld, hi_vld, lo_vld}, 0);
            end
            if (e == 2 && fresh)
                chk("R9", "no result before closing sync", {word_vld, hi_vld, lo_vld}, 0);
            if (e == 1 && err_e1) chk("R8", "early sync error", frame_err, 1);
            if (e == last - 1) chk("R7", "no error before expected edge", frame_err, 0);
            if (e == last) chk("R7", "missing sync error", frame_err, 1);
        end
    endtask

    task automatic load_row(logic [32:0] v, output bit bm, output int n);
        bm = v[32];
        if (!bm) begin
            frm[0] = v[31:16];
            frm[1] = v[15:0];
            n = 2;
        end else begin
            frm[0] = {8'h00, v[31:24]};
            frm[1] = {8'h00, v[23:16]};
            frm[2] = {8'h00, v[15:8]};
            frm[3] = {8'h00, v[7:0]};
            n = 4;
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        errs++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

    initial begin
        bit bm;
        int n;
        repeat (3) @(posedge sclk);
        #0.5;
        // R10: reset state
        chk("R10", "word_q reset", word_q, 0);
        chk("R10", "strobes reset", {word_vld, hi_vld, lo_vld, frame_err}, 0);
        @(negedge sclk);
        rst_n = 1'b1;
        #0.2;
        chk("R10", "hi/lo reset", {hi_q, lo_q}, 0);

        // table walk: each row ends with a missing sync (R7), then resyncs
        for (int i = 0; i < NV; i++) begin
            load_row(VEC[i], bm, n);
            run_frames(bm, n, 1'b1, 1'b0, 1'b0);
            // R6: result held after the error
            if (!bm) chk("R6", "word_q held", word_q, frm[n-1]);
            else     chk("R6", "lo_q held", lo_q, frm[n-1][B-1:0]);
        end

        // R11: byte_mode toggled inside word frames is ignored
        frm[0] = 16'h5A0F;
        frm[1] = 16'hC381;
        run_frames(1'b0, 2, 1'b1, 1'b0, 1'b1);

        // R8: early sync after five clocks, then a clean frame pair
        byte_mode = 1'b0;
        edge_drive(1'b1, 1'b1);
        for (int e = 1; e < 5; e++) edge_drive(1'b0, 1'b1);
        frm[0] = 16'h9B3D;
        frm[1] = 16'h4E72;
        run_frames(1'b0, 2, 1'b1, 1'b1, 1'b0);

        // R8 in byte mode: early rise restarts phase at upper byte
        byte_mode = 1'b1;
        edge_drive(1'b1, 1'b0);
        for (int e = 1; e < 3; e++) edge_drive(1'b0, 1'b0);
        frm[0] = 16'h00C5;
        frm[1] = 16'h003A;
        run_frames(1'b1, 2, 1'b1, 1'b1, 1'b0);

        // R10: reset in the middle of a stream, then R9 after it
        byte_mode = 1'b0;
        edge_drive(1'b1, 1'b1);
        for (int e = 1; e < 7; e++) edge_drive(1'b0, 1'b1);
        rst_n = 1'b0;
        #0.5;
        chk("R10", "outputs after mid reset", {word_q, hi_q, lo_q}, 0);
        chk("R10", "strobes after mid reset", {word_vld, hi_vld, lo_vld, frame_err}, 0);
        @(negedge sclk);
        rst_n = 1'b1;
        #0.2;
        frm[0] = 16'h0F0F;
        frm[1] = 16'hF00F;
        run_frames(1'b0, 2, 1'b1, 1'b0, 1'b0);

        report();
    end

endmodule